// File: doc/BRIEF.md
# Interleaved I/Q Sample Router

This block connects a radio front end that moves one 12-bit sample per clock to on-chip logic that handles whole complex samples. On the receive side it watches an I/Q select line. It keeps each I sample until the Q sample that follows it arrives. It then hands the pair on as one 24-bit word. On the transmit side it does the reverse. It takes a 24-bit word and drives the I half and then the Q half on consecutive cycles, raising the select line during the I cycle.

Three one-bit control registers sit on a simple write/read bus and set the routing:
- **Transmit source.** Either a built-in pattern generator or an external valid/ready stream feeds the transmit side.
- **Loopback.** The receive packer can take the block's own transmit samples in place of the radio pins.
- **Receive sink.** Each packed word goes to either a valid/ready stream port or a second valid/ready port that feeds a DMA engine.

A completed word that finds its sink still holding an unaccepted word is dropped. A drop sets a sticky flag that software can read and clear. All logic runs on one clock; the radio clocks are taken to be the system clock.

Top module: `iq_router`

## Requirements
- R1: After reset, all control registers read 0 (pattern generator, radio pins, stream sink, no overflow). Both sink valids are low, and the transmit pins idle at sample 0 with select low.
- R2: The transmit side emits a word as two consecutive cycles: bits 23:12 with select high (I), then bits 11:0 with select low (Q). With no word available it drives sample 0 with select low.
- R3: With transmit source 0, the generator supplies words with a 12-bit counter in I and its bitwise inverse in Q. The counter starts at 0 after reset and advances by one per word sent.
- R4: With transmit source 1, the transmit ready output is high exactly in cycles where no Q half is pending. A stream word is taken when ready and valid are both high.
- R5: The receive packer treats select high as I and select low as Q. A Q directly after an I produces the word {I, Q} (I in bits 23:12, Q in bits 11:0), valid in the cycle after the Q was presented.
- R6: A Q sample with no stored I is discarded. An I followed by another I keeps only the later one.
- R7: With loopback set to 1, the packer takes the block's own transmit pins in place of the radio receive pins.
- R8: A packed word goes to the stream port when the sink register is 0, and to the DMA-side port when it is 1.
- R9: A valid word on either sink port stays valid and unchanged until ready is seen high.
- R10: A completed word whose sink still holds an unaccepted word (valid high, ready low) is discarded. The discard sets the overflow flag at offset 0x10, bit 0, which stays set until a write of 1 to bit 0 of that offset.
- R11: Registers are at byte offsets 0x00 (transmit source), 0x08 (loopback) and 0x0C (receive sink), each in bit 0. Writes take effect at the clock edge, read data is combinational from the address, and unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used as both radio clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sample_i | input | SW | Radio receive sample |
| rx_isel_i | input | 1 | Radio receive select, high for I |
| tx_sample_o | output | SW | Radio transmit sample |
| tx_isel_o | output | 1 | Radio transmit select, high for I |
| tx_word_i | input | 2*SW | External transmit word, I in upper half |
| tx_valid_i | input | 1 | External transmit word valid |
| tx_ready_o | output | 1 | Block can take an external transmit word |
| rxs_word_o | output | 2*SW | Stream sink word |
| rxs_valid_o | output | 1 | Stream sink valid |
| rxs_ready_i | input | 1 | Stream sink ready |
| dma_word_o | output | 2*SW | DMA-side sink word |
| dma_valid_o | output | 1 | DMA-side sink valid |
| dma_ready_i | input | 1 | DMA-side sink ready |
| reg_wen_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register byte offset |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data |

## Verification
Several receive patterns are used, and each separates a different fault:
- Clean alternating I/Q pairs show the half ordering within the word.
- Lone Q samples, repeated I samples and idle gaps expose a packer that pairs the wrong samples or keeps stale state.
- Holding ready low across a second completed word separates holding a word from overwriting it, and tests the sticky drop flag and its clear.

Loopback with the generator, and then with a stream source whose valid toggles, covers the transmit split, the counter and its inverse, and the ready timing. A long mixed phase with random register writes checks every output against a behavioural model on every cycle.

// File: rtl/iq_router_pkg.sv
package iq_router_pkg;

    typedef enum logic {
        SRC_GEN    = 1'b0,
        SRC_STREAM = 1'b1
    } tx_src_e;

    typedef enum logic {
        SINK_STREAM = 1'b0,
        SINK_DMA    = 1'b1
    } rx_sink_e;

    typedef struct packed {
        tx_src_e  tx_src;
        logic     loopback;
        rx_sink_e rx_sink;
    } cfg_t;

    localparam int OFF_TX_SRC   = 'h00;
    localparam int OFF_LOOPBACK = 'h08;
    localparam int OFF_RX_SINK  = 'h0C;
    localparam int OFF_OVF      = 'h10;

endpackage

// File: rtl/iq_ctrl_regs.sv
module iq_ctrl_regs
    import iq_router_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          ovf_set_i,
    output cfg_t          cfg_o,
    output logic          ovf_o,
    output logic [DW-1:0] rdata_o
);

    typedef struct packed {
        cfg_t cfg;
        logic ovf;
    } regs_t;

    regs_t st_d, st_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DW-1:1];

    always_comb begin
        st_d = st_q;
        if (wen_i) begin
            if (addr_i == AW'(OFF_TX_SRC))   st_d.cfg.tx_src   = tx_src_e'(wdata_i[0]);
            if (addr_i == AW'(OFF_LOOPBACK)) st_d.cfg.loopback = wdata_i[0];
            if (addr_i == AW'(OFF_RX_SINK))  st_d.cfg.rx_sink  = rx_sink_e'(wdata_i[0]);
            if (addr_i == AW'(OFF_OVF) && wdata_i[0]) st_d.ovf = 1'b0;
        end
        // a new drop in the same cycle as a clear wins
        if (ovf_set_i) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(OFF_TX_SRC))   rdata_o[0] = st_q.cfg.tx_src;
        if (addr_i == AW'(OFF_LOOPBACK)) rdata_o[0] = st_q.cfg.loopback;
        if (addr_i == AW'(OFF_RX_SINK))  rdata_o[0] = st_q.cfg.rx_sink;
        if (addr_i == AW'(OFF_OVF))      rdata_o[0] = st_q.ovf;
    end

    assign cfg_o = st_q.cfg;
    assign ovf_o = st_q.ovf;

endmodule

// File: rtl/iq_test_gen.sv
module iq_test_gen #(
    parameter int SW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    output logic [2*SW-1:0] word_o
);

    typedef struct packed {
        logic [SW-1:0] cnt;
    } gen_t;

    gen_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = {st_q.cnt, ~st_q.cnt};

endmodule

// File: rtl/iq_tx_splitter.sv
module iq_tx_splitter #(
    parameter int SW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*SW-1:0] word_i,
    input  logic            avail_i,
    output logic            slot_o,
    output logic            take_o,
    output logic [SW-1:0]   sample_o,
    output logic            isel_o
);

    typedef struct packed {
        logic          q_pend;
        logic [SW-1:0] hold;
        logic [SW-1:0] sample;
        logic          isel;
    } split_t;

    split_t st_d, st_q;

    assign slot_o = !st_q.q_pend;
    assign take_o = !st_q.q_pend && avail_i;

    always_comb begin
        st_d        = st_q;
        st_d.q_pend = 1'b0;
        st_d.sample = '0;
        st_d.isel   = 1'b0;
        if (st_q.q_pend) begin
            st_d.sample = st_q.hold;
        end else if (avail_i) begin
            st_d.sample = word_i[2*SW-1:SW];
            st_d.isel   = 1'b1;
            st_d.hold   = word_i[SW-1:0];
            st_d.q_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_o = st_q.sample;
    assign isel_o   = st_q.isel;

endmodule

// File: rtl/iq_rx_packer.sv
module iq_rx_packer #(
    parameter int SW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW-1:0]   sample_i,
    input  logic            isel_i,
    output logic            done_o,
    output logic [2*SW-1:0] word_o
);

    typedef struct packed {
        logic          have_i;
        logic [SW-1:0] i_hold;
    } pack_t;

    pack_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (isel_i) begin
            st_d.have_i = 1'b1;
            st_d.i_hold = sample_i;
        end else begin
            st_d.have_i = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = !isel_i && st_q.have_i;
    assign word_o = {st_q.i_hold, sample_i};

endmodule

// File: rtl/iq_sink_slot.sv
module iq_sink_slot #(
    parameter int WW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [WW-1:0] word_i,
    input  logic          ready_i,
    output logic          valid_o,
    output logic [WW-1:0] word_o,
    output logic          drop_o
);

    typedef struct packed {
        logic          valid;
        logic [WW-1:0] word;
    } slot_t;

    slot_t st_d, st_q;
    logic  blocked;

    assign blocked = st_q.valid && !ready_i;
    assign drop_o  = load_i && blocked;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && ready_i) st_d.valid = 1'b0;
        if (load_i && !blocked) begin
            st_d.valid = 1'b1;
            st_d.word  = word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign word_o  = st_q.word;

endmodule

// File: rtl/iq_router.sv
module iq_router
    import iq_router_pkg::*;
#(
    parameter int SW = 12,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW-1:0]   rx_sample_i,
    input  logic            rx_isel_i,
    output logic [SW-1:0]   tx_sample_o,
    output logic            tx_isel_o,
    input  logic [2*SW-1:0] tx_word_i,
    input  logic            tx_valid_i,
    output logic            tx_ready_o,
    output logic [2*SW-1:0] rxs_word_o,
    output logic            rxs_valid_o,
    input  logic            rxs_ready_i,
    output logic [2*SW-1:0] dma_word_o,
    output logic            dma_valid_o,
    input  logic            dma_ready_i,
    input  logic            reg_wen_i,
    input  logic [AW-1:0]   reg_addr_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o
);

    localparam int WW    = 2 * SW;
    localparam int NSINK = 2;

    cfg_t          cfg;
    logic          ovf_flag;
    logic          ovf_set;
    logic          src_stream;
    logic          sink_dma;

    logic [WW-1:0] gen_word;
    logic          gen_take;
    logic [WW-1:0] tx_word_sel;
    logic          tx_avail;
    logic          tx_slot;
    logic          tx_take;

    logic [SW-1:0] pk_sample;
    logic          pk_isel;
    logic          pk_done;
    logic [WW-1:0] pk_word;

    logic [NSINK-1:0] slot_load;
    logic [NSINK-1:0] slot_ready;
    logic [NSINK-1:0] slot_valid;
    logic [NSINK-1:0] slot_drop;
    logic [WW-1:0]    slot_word [NSINK];

    assign src_stream = (cfg.tx_src == SRC_STREAM);
    assign sink_dma   = (cfg.rx_sink == SINK_DMA);

    iq_ctrl_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wen_i    (reg_wen_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .ovf_set_i(ovf_set),
        .cfg_o    (cfg),
        .ovf_o    (ovf_flag),
        .rdata_o  (reg_rdata_o)
    );

    // transmit source selection
    assign tx_word_sel = src_stream ? tx_word_i : gen_word;
    assign tx_avail    = src_stream ? tx_valid_i : 1'b1;
    assign gen_take    = tx_take && !src_stream;
    assign tx_ready_o  = tx_slot && src_stream;

    iq_test_gen #(.SW(SW)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .take_i(gen_take),
        .word_o(gen_word)
    );

    iq_tx_splitter #(.SW(SW)) u_split (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_i  (tx_word_sel),
        .avail_i (tx_avail),
        .slot_o  (tx_slot),
        .take_o  (tx_take),
        .sample_o(tx_sample_o),
        .isel_o  (tx_isel_o)
    );

    // receive input selection
    assign pk_sample = cfg.loopback ? tx_sample_o : rx_sample_i;
    assign pk_isel   = cfg.loopback ? tx_isel_o   : rx_isel_i;

    iq_rx_packer #(.SW(SW)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample_i(pk_sample),
        .isel_i  (pk_isel),
        .done_o  (pk_done),
        .word_o  (pk_word)
    );

    assign slot_ready[0] = rxs_ready_i;
    assign slot_ready[1] = dma_ready_i;

    for (genvar g = 0; g < NSINK; g++) begin : g_sink
        assign slot_load[g] = pk_done && (sink_dma == (g == 1));

        iq_sink_slot #(.WW(WW)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (slot_load[g]),
            .word_i (pk_word),
            .ready_i(slot_ready[g]),
            .valid_o(slot_valid[g]),
            .word_o (slot_word[g]),
            .drop_o (slot_drop[g])
        );
    end

    assign ovf_set     = |slot_drop;
    assign rxs_valid_o = slot_valid[0];
    assign rxs_word_o  = slot_word[0];
    assign dma_valid_o = slot_valid[1];
    assign dma_word_o  = slot_word[1];

endmodule

// File: rtl/iq_router_chk.sv
module iq_router_chk #(
    parameter int SW = 12,
    parameter int AW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [SW-1:0]   tx_sample,
    input logic            tx_isel,
    input logic            tx_ready,
    input logic [2*SW-1:0] rxs_word,
    input logic            rxs_valid,
    input logic            rxs_ready,
    input logic [2*SW-1:0] dma_word,
    input logic            dma_valid,
    input logic            dma_ready,
    input logic            src_stream,
    input logic            sink_dma,
    input logic            ovf,
    input logic            wen,
    input logic [AW-1:0]   addr,
    input logic            wbit0
);

    logic ovf_clr;
    assign ovf_clr = wen && (addr == AW'('h10)) && wbit0;

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rxs_valid && !dma_valid && !tx_isel));

    assert_q_follows_i_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_isel |=> !tx_isel);

    assert_gen_inverse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_isel && !$past(src_stream)) |=> (tx_sample == ~$past(tx_sample)));

    assert_ready_in_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !tx_isel);

    assert_stream_sink_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxs_valid) |-> !$past(sink_dma));

    assert_dma_sink_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_valid) |-> $past(sink_dma));

    assert_rxs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rxs_valid && !rxs_ready) |=> (rxs_valid && $stable(rxs_word)));

    assert_dma_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_word)));

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

endmodule

bind iq_router iq_router_chk #(.SW(SW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_sample (tx_sample_o),
    .tx_isel   (tx_isel_o),
    .tx_ready  (tx_ready_o),
    .rxs_word  (rxs_word_o),
    .rxs_valid (rxs_valid_o),
    .rxs_ready (rxs_ready_i),
    .dma_word  (dma_word_o),
    .dma_valid (dma_valid_o),
    .dma_ready (dma_ready_i),
    .src_stream(src_stream),
    .sink_dma  (sink_dma),
    .ovf       (ovf_flag),
    .wen       (reg_wen_i),
    .addr      (reg_addr_i),
    .wbit0     (reg_wdata_i[0])
);

// File: tb/sim_iq_router.sv
`timescale 1ns/1ps
module sim_iq_router;

    localparam int SW = 12;
    localparam int WW = 24;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] rx_sample = '0;
    logic          rx_isel = 1'b0;
    logic [SW-1:0] tx_sample;
    logic          tx_isel;
    logic [WW-1:0] tx_word = '0;
    logic          tx_valid = 1'b0;
    logic          tx_ready;
    logic [WW-1:0] rxs_word;
    logic          rxs_valid;
    logic          rxs_ready = 1'b0;
    logic [WW-1:0] dma_word;
    logic          dma_valid;
    logic          dma_ready = 1'b0;
    logic          reg_wen = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;

    always #2.5 clk = ~clk;

    iq_router #(.SW(SW), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_sample_i(rx_sample), .rx_isel_i(rx_isel),
        .tx_sample_o(tx_sample), .tx_isel_o(tx_isel),
        .tx_word_i(tx_word), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
        .rxs_word_o(rxs_word), .rxs_valid_o(rxs_valid), .rxs_ready_i(rxs_ready),
        .dma_word_o(dma_word), .dma_valid_o(dma_valid), .dma_ready_i(dma_ready),
        .reg_wen_i(reg_wen), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    finished = 0;
    string tag = "R1";

    // ---------------- behavioural reference ----------------
    int       m_src, m_loop, m_sink, m_ovf, m_gen, m_pend, m_tx;
    int       txq[$];
    bit       m_v[2];
    int       m_w[2];

    always @(posedge clk) begin
        int  s;
        int  isel;
        int  w;
        bit  done;
        bit  ovf_hit;
        bit  rdy[2];
        if (!rst_n) begin
            m_src = 0; m_loop = 0; m_sink = 0; m_ovf = 0; m_gen = 0;
            m_pend = -1; m_tx = 0; txq.delete();
            m_v[0] = 0; m_v[1] = 0; m_w[0] = 0; m_w[1] = 0;
        end else begin
            rdy[0] = rxs_ready; rdy[1] = dma_ready;
            if (m_loop != 0) begin s = m_tx & 'hFFF; isel = (m_tx >> 12) & 1; end
            else begin s = int'(rx_sample); isel = int'(rx_isel); end
            done = 0; w = 0;
            if (isel != 0) m_pend = s;
            else if (m_pend >= 0) begin
                w = (m_pend << 12) | s; done = 1; m_pend = -1;
            end
            for (int k = 0; k < 2; k++) if (m_v[k] && rdy[k]) m_v[k] = 0;
            ovf_hit = 0;
            if (done) begin
                if (m_v[m_sink]) ovf_hit = 1;
                else begin m_v[m_sink] = 1; m_w[m_sink] = w; end
            end
            if (txq.size() == 0) begin
                if (m_src == 0) begin
                    txq.push_back('h1000 | m_gen);
                    txq.push_back((~m_gen) & 'hFFF);
                    m_gen = (m_gen + 1) & 'hFFF;
                end else if (tx_valid) begin
                    txq.push_back('h1000 | int'(tx_word[23:12]));
                    txq.push_back(int'(tx_word[11:0]));
                end
            end
            m_tx = (txq.size() != 0) ? txq.pop_front() : 0;
            if (reg_wen) begin
                case (int'(reg_addr))
                    'h00: m_src  = int'(reg_wdata[0]);
                    'h08: m_loop = int'(reg_wdata[0]);
                    'h0C: m_sink = int'(reg_wdata[0]);
                    'h10: if (reg_wdata[0]) m_ovf = 0;
                    default: ;
                endcase
            end
            if (ovf_hit) m_ovf = 1;
        end
    end

    function automatic int exp_rdata(int a);
        case (a)
            'h00: return m_src;
            'h08: return m_loop;
            'h0C: return m_sink;
            'h10: return m_ovf;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string sig, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, sig, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("tx_sample(R2)", int'(tx_sample), m_tx & 'hFFF);
        chk("tx_isel(R2)", int'(tx_isel), (m_tx >> 12) & 1);
        chk("tx_ready(R4)", int'(tx_ready), (txq.size() == 0 && m_src == 1) ? 1 : 0);
        chk("rxs_valid(R8)", int'(rxs_valid), int'(m_v[0]));
        if (m_v[0]) chk("rxs_word(R5)", int'(rxs_word), m_w[0]);
        chk("dma_valid(R8)", int'(dma_valid), int'(m_v[1]));
        if (m_v[1]) chk("dma_word(R5)", int'(dma_word), m_w[1]);
        chk("rdata(R11)", int'(reg_rdata), exp_rdata(int'(reg_addr)));
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(int a, int d);
        reg_wen = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
        step();
        reg_wen = 1'b0;
    endtask

    task automatic rx_put(int smp, bit is_i);
        rx_sample = SW'(smp); rx_isel = is_i;
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired in phase %s", tag);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state and register readback
        tag = "R1";
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("rxs_valid in reset (R1)", int'(rxs_valid), 0);
        chk("dma_valid in reset (R1)", int'(dma_valid), 0);
        chk("tx_isel in reset (R1)", int'(tx_isel), 0);
        rst_n = 1'b1;
        foreach (reg_addr[i]) begin end
        for (int a = 0; a <= 'h14; a += 4) begin
            reg_addr = AW'(a);
            @(negedge clk);
            chk("rdata after reset (R1)", int'(reg_rdata), 0);
        end
        reg_addr = '0;

        // R2 / R3: generator drives the transmit pins
        tag = "R3 generator";
        repeat (12) step();
        tag = "R2 split";
        repeat (4) step();

        // R5: clean pairs to the stream sink
        tag = "R5 pack";
        rxs_ready = 1'b1;
        rx_put('h123, 1); rx_put('h456, 0);
        rx_put('hABC, 1); rx_put('h0F0, 0);
        rx_put(0, 0);
        @(negedge clk);
        chk("rxs_word pair (R5)", int'(rxs_word), 'hABC0F0);
        rx_put('hFFF, 1); rx_put('h001, 0); rx_put(0, 0); rx_put(0, 0);

        // R6: lone Q and repeated I
        tag = "R6 orphan";
        rx_put('h777, 0); rx_put('h778, 0);
        chk("lone Q gives no word (R6)", int'(rxs_valid), 0);
        rx_put('h111, 1); rx_put('h222, 1); rx_put('h333, 0);
        chk("later I kept (R6)", int'(rxs_word), 'h222333);
        rx_put(0, 0);

        // R9: hold while ready low
        tag = "R9 hold";
        rxs_ready = 1'b0;
        rx_put('h5A5, 1); rx_put('hA5A, 0);
        rx_put(0, 0); rx_put(0, 0); rx_put(0, 0);
        chk("held word (R9)", int'(rxs_word), 'h5A5A5A);
        rxs_ready = 1'b1; step(); step();

        // R10: overflow drop and sticky flag
        tag = "R10 overflow";
        rxs_ready = 1'b0;
        rx_put('h100, 1); rx_put('h200, 0);
        rx_put('h300, 1); rx_put('h400, 0);
        reg_addr = AW'('h10); step();
        chk("overflow flag (R10)", int'(reg_rdata), 1);
        chk("first word kept (R10)", int'(rxs_word), 'h100200);
        rxs_ready = 1'b1; repeat (3) step();
        chk("flag sticky (R10)", int'(reg_rdata), 1);
        wr('h10, 1);
        chk("flag cleared (R10)", int'(reg_rdata), 0);

        // R8: route to the DMA-side port
        tag = "R8 dma sink";
        wr('h0C, 1);
        dma_ready = 1'b1;
        rx_put('h9AB, 1); rx_put('hCDE, 0);
        rx_put(0, 0);
        chk("dma word (R8)", int'(dma_word), 'h9ABCDE);
        chk("stream idle (R8)", int'(rxs_valid), 0);
        dma_ready = 1'b0;
        rx_put('h010, 1); rx_put('h020, 0); rx_put(0, 0); rx_put(0, 0);
        dma_ready = 1'b1; step();
        wr('h0C, 0);

        // R7: loopback of generator samples
        tag = "R7 loopback";
        rx_sample = 'hEEE; rx_isel = 1'b1;
        wr('h08, 1);
        repeat (30) step();

        // R4: stream source with toggling valid
        tag = "R4 stream src";
        wr('h00, 1);
        for (int i = 0; i < 60; i++) begin
            tx_valid = (i % 3) != 1;
            tx_word  = WW'(32'h00ABC000 + i * 'h1001);
            step();
        end
        tx_valid = 1'b0;
        repeat (6) step();

        // R11: mixed random traffic with register writes
        tag = "R11 mixed";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 15));
            rx_sample = SW'($urandom);
            rx_isel   = $urandom_range(0, 1) == 1;
            tx_word   = WW'($urandom);
            tx_valid  = $urandom_range(0, 3) != 0;
            rxs_ready = $urandom_range(0, 3) != 0;
            dma_ready = $urandom_range(0, 3) != 0;
            reg_addr  = AW'(4 * $urandom_range(0, 5));
            reg_wen   = (r == 0);
            reg_wdata = DW'($urandom);
            step();
            reg_wen = 1'b0;
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule